// File: doc/BRIEF.md
# Single-Wire Slave ROM Addressing Layer

This block is the network layer of a slave on a multidrop single-wire bus. After every bus reset it takes an 8-bit ROM command from the master. It then either sends its 64-bit identity, compares a 64-bit identity sent by the master, takes part in a bitwise search arbitration, or skips straight ahead. When the command completes successfully, it grants the memory-function layer access to the bus. Otherwise it falls silent until the next bus reset.

The identity is built from a family code and a 48-bit serial number, both supplied as parameters, followed by a CRC byte. After the power-on reset the block computes that CRC serially, one bit per clock. A separate bit-level link engine handles slot timing. For each completed time slot it gives this block one strobe and the bit sampled on the line. It drives the line low in a slot only when this block asks to transmit a 0.

Top module: `sw_rom_net`

## Requirements
- R1: After `rst` and before the first `bus_reset`, time slots are ignored: `tx_en` and `mem_grant` stay 0 even if a complete skip command (CCh) is clocked in.
- R2: A `bus_reset` pulse abandons any exchange in progress and any granted access, and restarts command reception. In the cycle after the pulse, `tx_en` and `mem_grant` are both 0.
- R3: The command is taken from 8 slots, least significant bit first. 33h selects identity read, 55h identity match, F0h search and CCh skip. Any other code leaves `tx_en` and `mem_grant` at 0 through every later slot until a `bus_reset`. `mem_grant` can only rise in the cycle after a slot strobe.
- R4: Skip (CCh) raises `mem_grant` right after the 8th command slot, with no identity exchange. The grant stays high until a `bus_reset`.
- R5: Identity read (33h) sends 64 bits, one per slot, with `tx_en` high in each slot. Bits 0-7 are the family code, bits 8-55 the serial number and bits 56-63 the CRC, each field LSB first. `mem_grant` rises after the 64th slot.
- R6: The CRC byte uses the polynomial x^8+x^5+x^4+1 with a zero start value. It is fed the 56 family and serial bits LSB first. Feeding the whole 64-bit transmitted identity through the same register leaves it at zero.
- R7: Identity match (55h) compares 64 master-written bits against the identity in transmission order. If all bits match, `mem_grant` rises after the 64th slot. On any mismatch the block stays silent with no grant until a `bus_reset`.
- R8: Search (F0h) uses three slots per identity bit. In the first slot the block sends the bit, in the second its complement (`tx_en` high in both), and in the third it reads the master's bit (`tx_en` low). If the master's bit equals the block's bit, the search continues and `mem_grant` rises after the 64th bit. If the bits differ, the block drops out: `tx_en` stays low and no grant is given until a `bus_reset`.
- R9: `tx_en` and `mem_grant` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; starts the CRC computation |
| bus_reset | input | 1 | One-cycle pulse: bus reset detected by the link engine |
| slot_done | input | 1 | One-cycle strobe: a time slot has completed |
| slot_bit | input | 1 | Line value sampled in the completed slot |
| tx_en | output | 1 | The block transmits in the coming slot |
| tx_bit | output | 1 | Bit to transmit (0 means pull the line low); 1 when not transmitting |
| mem_grant | output | 1 | ROM layer done; memory-function layer owns the bus |

## Verification
The bound checker watches four things on every cycle: that the outputs stay quiet before the first bus reset, that a bus reset clears them, that a grant is never seen while transmitting, and that once given a grant persists and only appears just after a slot. The bench shows what needs whole transactions. It sweeps all 256 command codes, compares the transmitted identity and its CRC residue against values computed in the bench, and checks match and search dropout at the first, last and interior bit positions.

// File: rtl/sw_rom_pkg.sv
package sw_rom_pkg;
    localparam int FAM_W  = 8;
    localparam int SER_W  = 48;
    localparam int CHK_W  = 8;
    localparam int ID_W   = FAM_W + SER_W + CHK_W;
    localparam int BODY_W = FAM_W + SER_W;
    localparam int IDX_W  = $clog2(ID_W);
    localparam int CMD_W  = 8;

    // reflected form of x^8 + x^5 + x^4 + 1
    localparam logic [CHK_W-1:0] CRC_POLY_REV = 8'h8C;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_SEND, ST_MATCH,
        ST_S_TRUE, ST_S_COMP, ST_S_PICK, ST_GRANT
    } net_state_e;

    typedef struct packed {
        net_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [CMD_W-1:0]   cmd;
    } net_ctx_t;

    function automatic logic [CHK_W-1:0] crc_step(input logic [CHK_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ ({CHK_W{fb}} & CRC_POLY_REV);
    endfunction

    function automatic net_state_e decode_op(input logic [CMD_W-1:0] op);
        case (op)
            OP_READ:   return ST_SEND;
            OP_MATCH:  return ST_MATCH;
            OP_SEARCH: return ST_S_TRUE;
            OP_SKIP:   return ST_GRANT;
            default:   return ST_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/rom_crc_gen.sv
module rom_crc_gen
    import sw_rom_pkg::*;
#(
    parameter int DATA_W = BODY_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  crc,
    output logic              ready
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] DONE_POS = CNT_W'(DATA_W);

    logic [CNT_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            crc <= '0;
        end else if (pos != DONE_POS) begin
            crc <= crc_step(crc, data[pos]);
            pos <= pos + 1'b1;
        end
    end

    assign ready = (pos == DONE_POS);
endmodule

// File: rtl/rom_id_sel.sv
module rom_id_sel
    import sw_rom_pkg::*;
(
    input  logic [FAM_W-1:0] family,
    input  logic [SER_W-1:0] serial,
    input  logic [CHK_W-1:0] crc,
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);
    logic [ID_W-1:0] ident;

    // transmission order: family, serial, crc, each LSB first
    assign ident  = {crc, serial, family};
    assign id_bit = ident[idx];
endmodule

// File: rtl/rom_net_fsm.sv
module rom_net_fsm
    import sw_rom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             slot_done,
    input  logic             slot_bit,
    input  logic             crc_ready,
    input  logic             id_bit,
    output logic [IDX_W-1:0] idx,
    output logic             tx_en,
    output logic             tx_bit,
    output logic             mem_grant
);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);

    net_ctx_t cur, nxt;
    logic     slot_ok;

    assign slot_ok = slot_done && crc_ready;

    always_comb begin
        nxt = cur;
        if (bus_reset) begin
            nxt.st  = ST_CMD;
            nxt.idx = '0;
            nxt.cmd = '0;
        end else if (slot_ok) begin
            case (cur.st)
                ST_CMD: begin
                    nxt.cmd = {slot_bit, cur.cmd[CMD_W-1:1]};
                    if (cur.idx == CMD_LAST) begin
                        nxt.idx = '0;
                        nxt.st  = decode_op(nxt.cmd);
                    end else begin
                        nxt.idx = cur.idx + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (cur.idx == ID_LAST) nxt.st = ST_GRANT;
                    else                    nxt.idx = cur.idx + 1'b1;
                end
                ST_MATCH: begin
                    if (slot_bit != id_bit)      nxt.st = ST_IDLE;
                    else if (cur.idx == ID_LAST) nxt.st = ST_GRANT;
                    else                         nxt.idx = cur.idx + 1'b1;
                end
                ST_S_TRUE: nxt.st = ST_S_COMP;
                ST_S_COMP: nxt.st = ST_S_PICK;
                ST_S_PICK: begin
                    if (slot_bit != id_bit)      nxt.st = ST_IDLE;
                    else if (cur.idx == ID_LAST) nxt.st = ST_GRANT;
                    else begin
                        nxt.idx = cur.idx + 1'b1;
                        nxt.st  = ST_S_TRUE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st  <= ST_IDLE;
            cur.idx <= '0;
            cur.cmd <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign idx       = cur.idx;
    assign tx_en     = (cur.st == ST_SEND) || (cur.st == ST_S_TRUE) || (cur.st == ST_S_COMP);
    assign tx_bit    = !tx_en ? 1'b1 : ((cur.st == ST_S_COMP) ? ~id_bit : id_bit);
    assign mem_grant = (cur.st == ST_GRANT);
endmodule

// File: rtl/sw_rom_net.sv
module sw_rom_net
    import sw_rom_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h3A,
    parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_5E1D_93C4
)(
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic slot_done,
    input  logic slot_bit,
    output logic tx_en,
    output logic tx_bit,
    output logic mem_grant
);
    logic [CHK_W-1:0] crc;
    logic             crc_ready;
    logic [IDX_W-1:0] idx;
    logic             id_bit;

    rom_crc_gen #(.DATA_W(BODY_W)) u_crc (
        .clk   (clk),
        .rst   (rst),
        .data  ({SERIAL_NUM, FAMILY_CODE}),
        .crc   (crc),
        .ready (crc_ready)
    );

    rom_id_sel u_sel (
        .family (FAMILY_CODE),
        .serial (SERIAL_NUM),
        .crc    (crc),
        .idx    (idx),
        .id_bit (id_bit)
    );

    rom_net_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .slot_done (slot_done),
        .slot_bit  (slot_bit),
        .crc_ready (crc_ready),
        .id_bit    (id_bit),
        .idx       (idx),
        .tx_en     (tx_en),
        .tx_bit    (tx_bit),
        .mem_grant (mem_grant)
    );
endmodule

// File: rtl/sw_rom_net_chk.sv
module sw_rom_net_chk (
    input logic clk,
    input logic rst,
    input logic bus_reset,
    input logic slot_done,
    input logic tx_en,
    input logic mem_grant
);
    logic seen_bus_reset;

    always_ff @(posedge clk) begin
        if (rst)            seen_bus_reset <= 1'b0;
        else if (bus_reset) seen_bus_reset <= 1'b1;
    end

    // R1
    quiet_before_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_bus_reset |-> (!tx_en && !mem_grant));

    // R2
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (!tx_en && !mem_grant));

    // R9
    no_tx_when_granted_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_en && mem_grant));

    // R4
    grant_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_grant && !bus_reset) |=> mem_grant);

    // R3
    grant_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_grant) |-> $past(slot_done));
endmodule

bind sw_rom_net sw_rom_net_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_reset (bus_reset),
    .slot_done (slot_done),
    .tx_en     (tx_en),
    .mem_grant (mem_grant)
);

// File: tb/sw_rom_net_test.sv
`timescale 1ns/1ps
module sw_rom_net_test;
    localparam logic [7:0]  FAM = 8'h3A;
    localparam logic [47:0] SER = 48'h0000_5E1D_93C4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0;
    logic slot_done = 1'b0;
    logic slot_bit  = 1'b1;
    logic tx_en, tx_bit, mem_grant;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0]  exp_crc;
    logic [63:0] exp_id;

    always #2.5 clk = ~clk;

    sw_rom_net #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .slot_done(slot_done),
        .slot_bit(slot_bit), .tx_en(tx_en), .tx_bit(tx_bit), .mem_grant(mem_grant)
    );

    function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            if ((c[0] ^ v[i]) == 1'b1) c = (c >> 1) ^ 8'h8C;
            else                       c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic pulse_bus_reset();
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    // one slot: master writes b, or reads the line when the block transmits
    task automatic slot(input logic b, output logic line);
        line = tx_en ? tx_bit : b;
        slot_bit  = line;
        slot_done = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
        slot_bit  = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic l;
        for (int i = 0; i < 8; i++) slot(v[i], l);
    endtask

    task automatic run_search(input int flip_at);
        logic t, c, l;
        bit   tx_ok;
        pulse_bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            tx_ok = tx_en;
            slot(1'b1, t);
            tx_ok = tx_ok && tx_en;
            slot(1'b1, c);
            if (flip_at < 0) begin
                check(tx_ok && t == exp_id[i] && c == ~exp_id[i], "R8 search bit/complement",
                      {62'd0, t, c}, {62'd0, exp_id[i], ~exp_id[i]});
                check(!tx_en, "R8 pick slot tx_en", {63'd0, tx_en}, 64'd0);
            end
            slot((i == flip_at) ? ~t : t, l);
            if (i == flip_at) break;
        end
        if (flip_at < 0) begin
            check(mem_grant, "R8 search grant", {63'd0, mem_grant}, 64'd1);
        end else begin
            for (int k = 0; k < 6; k++) slot(1'b1, t);
            check(!tx_en && !mem_grant, "R8 search dropout",
                  {62'd0, tx_en, mem_grant}, 64'd0);
        end
    endtask

    task automatic run_match(input int flip_at);
        logic l;
        pulse_bus_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) begin
            if (i == 63 && flip_at < 0)
                check(!mem_grant, "R7 no early grant", {63'd0, mem_grant}, 64'd0);
            slot((i == flip_at) ? ~exp_id[i] : exp_id[i], l);
        end
        if (flip_at < 0) begin
            check(mem_grant, "R7 match grant", {63'd0, mem_grant}, 64'd1);
        end else begin
            for (int k = 0; k < 8; k++) slot(1'b0, l);
            check(!tx_en && !mem_grant, "R7 mismatch silent",
                  {62'd0, tx_en, mem_grant}, 64'd0);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL R2 watchdog expired act=%0d exp=done", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] got;
        logic        l;
        bit          tx_all;
        exp_crc = ref_crc({8'h00, SER, FAM}, 56);
        exp_id  = {exp_crc, SER, FAM};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_en && !mem_grant, "R1 reset state", {62'd0, tx_en, mem_grant}, 64'd0);
        repeat (80) @(negedge clk);
        send_byte(8'hCC);
        check(!tx_en && !mem_grant, "R1 slots before bus reset ignored",
              {62'd0, tx_en, mem_grant}, 64'd0);

        // R3 sweep over every command code
        for (int c = 0; c < 256; c++) begin
            pulse_bus_reset();
            check(!tx_en && !mem_grant, "R2 cleared by bus reset", {62'd0, tx_en, mem_grant}, 64'd0);
            send_byte(8'(c));
            check(mem_grant == (c == 8'hCC), "R4 grant only for skip",
                  {63'd0, mem_grant}, {63'd0, (c == 8'hCC)});
            check(tx_en == (c == 8'h33 || c == 8'hF0), "R3 tx_en per command",
                  {63'd0, tx_en}, {63'd0, (c == 8'h33 || c == 8'hF0)});
            if (c != 8'h33 && c != 8'h55 && c != 8'hF0 && c != 8'hCC) begin
                send_byte(8'hCC);
                check(!tx_en && !mem_grant, "R3 unknown command stays idle",
                      {62'd0, tx_en, mem_grant}, 64'd0);
            end
        end

        // R5 / R6 identity read
        pulse_bus_reset();
        send_byte(8'h33);
        tx_all = 1'b1;
        for (int i = 0; i < 64; i++) begin
            tx_all = tx_all && tx_en;
            slot(1'b1, l);
            got[i] = l;
        end
        check(tx_all, "R5 tx_en in every read slot", {63'd0, tx_all}, 64'd1);
        check(got == exp_id, "R5 identity bits", got, exp_id);
        check(got[63:56] == exp_crc, "R6 crc byte", {56'd0, got[63:56]}, {56'd0, exp_crc});
        check(ref_crc(got, 64) == 8'h00, "R6 zero residue", {56'd0, ref_crc(got, 64)}, 64'd0);
        check(mem_grant, "R5 grant after read", {63'd0, mem_grant}, 64'd1);
        check(!tx_en, "R9 quiet when granted", {63'd0, tx_en}, 64'd0);
        pulse_bus_reset();
        check(!mem_grant, "R2 grant cleared", {63'd0, mem_grant}, 64'd0);

        // R2 abort mid read
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) slot(1'b1, l);
        pulse_bus_reset();
        check(!tx_en && !mem_grant, "R2 abort read", {62'd0, tx_en, mem_grant}, 64'd0);
        send_byte(8'hCC);
        check(mem_grant, "R4 skip after abort", {63'd0, mem_grant}, 64'd1);

        // R7 match
        run_match(-1);
        run_match(0);
        run_match(7);
        run_match(31);
        run_match(56);
        run_match(63);

        // R8 search
        run_search(-1);
        run_search(0);
        run_search(20);
        run_search(63);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule